// File: doc/BRIEF.md
# 128-bit Packed Integer ALU

This block is a single-cycle execution unit for packed integer work on 128-bit vectors. A request presents an operation code, two 128-bit operands `a` and `b` and an 8-bit immediate together with a one-cycle `start` strobe. On the next clock edge the unit registers the 128-bit result and raises `done` for exactly one cycle. Requests may be issued on every cycle, so the unit behaves as a fully pipelined one-stage function.

The unit divides each vector into lanes. The lowest lane occupies the least significant bits, and this order applies to every lane-wise operation. Each operation has a fixed role for its operands. The shift and the pass-through act on `a`. The shuffle reads its lanes from `b`. All other operations combine `a` (the destination value) with `b` (the source value). Flags, register storage and memory addressing are handled by the surrounding datapath.

Top module: `simd_alu128`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit clears `result` to zero and `done` to 0.
- R2: A `start` sampled high at a rising edge raises `done` after that same edge, for one cycle. `done` stays low after any edge where `start` was low. `result` changes only on edges where `start` is high.
- R3: Op code 0 adds `a` and `b` in four 32-bit lanes. Lane k is bits [32k+31:32k]. Each sum wraps modulo 2^32, and no carry passes into the next lane.
- R4: Op code 1 adds `a` and `b` in two 64-bit lanes. Each sum wraps modulo 2^64 on its own.
- R5: Op code 2 returns the 128-bit bitwise AND of `a` and `b`. Op code 3 returns the 128-bit bitwise XOR.
- R6: Op code 4 compares each 32-bit lane of `a` with the same lane of `b` as signed numbers. The result lane is 0xFFFFFFFF when the `a` lane is greater, and 0 otherwise.
- R7: Op code 5 sets result lane i (i = 0..3) to lane `imm8[2i+1:2i]` of `b`. For example, imm8 = 0x55 copies lane 1 of `b` into all four lanes.
- R8: Op code 6 shifts each 32-bit lane of `a` right arithmetically by `imm8` when `imm8` is 31 or less.
- R9: Under op code 6, a count of 32 or more saturates. Every lane then becomes copies of its sign bit, which is 0 or 0xFFFFFFFF.
- R10: Op code 7 (unassigned) returns `a` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, one cycle per operation |
| op | input | 3 | Operation code (see R3 to R10) |
| a | input | 128 | Destination-side operand |
| b | input | 128 | Source-side operand |
| imm8 | input | 8 | Shuffle selectors or shift count |
| result | output | 128 | Registered result |
| done | output | 1 | Result-valid pulse, one cycle after start |

## Verification
A `done` pulse for one operation can fall in the same cycle as the `start` of the next one. In that cycle the result register must both present the old value and capture the new one, and the done pulse must stretch across the run instead of breaking up. The bench provokes this case by issuing long runs of back-to-back requests that mix every operation code. It pops one expected value per observed `done`, so a result that is late, lost or doubled shifts the queue and the mismatch is reported. It also checks the level of `done` each cycle against the strobe sampled at the previous edge.

// File: rtl/simd_alu_pkg.sv
// Package: shared operation codes and vector geometry for the packed ALU.
// Assumes: users import it before declaring ports that carry an op code.
package simd_alu_pkg;

    localparam int VEC_W   = 128;
    localparam int DWORD_W = 32;
    localparam int QWORD_W = 64;
    localparam int IMM_W   = 8;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD32 = 3'd0,
        OP_ADD64 = 3'd1,
        OP_AND   = 3'd2,
        OP_XOR   = 3'd3,
        OP_CMPGT = 3'd4,
        OP_SHUF  = 3'd5,
        OP_SRA   = 3'd6,
        OP_PASS  = 3'd7
    } alu_op_e;

endpackage

// File: rtl/simd_lane_add.sv
// Module: lane-split adder. Adds two vectors in independent lanes of LANE_W bits.
// Assumes: DATA_W is a whole multiple of LANE_W. Lanes never exchange carries.
module simd_lane_add #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] sum
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        // Purpose: wrap-around sum of one lane.
        assign sum[gi*LANE_W +: LANE_W] = x[gi*LANE_W +: LANE_W] + y[gi*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/simd_lane_cmp_sra.sv
// Module: per-lane signed compare mask and saturating arithmetic right shift.
// Assumes: the count is unsigned. Counts at or above LANE_W act as LANE_W-1,
// which yields the same sign fill that a full-width shift would give.
module simd_lane_cmp_sra #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] gt_mask,
    output logic [DATA_W-1:0] sra_out
);
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int SH_W      = $clog2(LANE_W);
    localparam logic [CNT_W-1:0] MAX_SH = CNT_W'(LANE_W - 1);

    logic [SH_W-1:0] eff_sh;

    // Purpose: clamp the immediate count so large values saturate to a sign fill.
    always_comb begin
        if (count > MAX_SH) begin
            eff_sh = SH_W'(LANE_W - 1);
        end else begin
            eff_sh = count[SH_W-1:0];
        end
    end

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        logic signed [LANE_W-1:0] xs;
        logic signed [LANE_W-1:0] ys;
        assign xs = x[gi*LANE_W +: LANE_W];
        assign ys = y[gi*LANE_W +: LANE_W];
        // Purpose: all-ones lane when x is the larger signed value.
        assign gt_mask[gi*LANE_W +: LANE_W] = (xs > ys) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
        // Purpose: shift in copies of the sign bit.
        assign sra_out[gi*LANE_W +: LANE_W] = xs >>> eff_sh;
    end

endmodule

// File: rtl/simd_lane_shuffle.sv
// Module: immediate-driven lane permute. Output lane i takes the input lane
// named by selector field i of sel (field i is bits [SEL_W*i +: SEL_W]).
// Assumes: NUM_LANES*SEL_W fits within SEL_BITS.
module simd_lane_shuffle #(
    parameter int DATA_W   = 128,
    parameter int LANE_W   = 32,
    parameter int SEL_BITS = 8
) (
    input  logic [DATA_W-1:0]   src,
    input  logic [SEL_BITS-1:0] sel,
    output logic [DATA_W-1:0]   dst
);
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int SEL_W     = $clog2(NUM_LANES);

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        logic [SEL_W-1:0] pick;
        assign pick = sel[gi*SEL_W +: SEL_W];
        // Purpose: route the chosen source lane to output lane gi.
        assign dst[gi*LANE_W +: LANE_W] = src[int'(pick)*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/simd_alu128.sv
// Module: top of the packed integer ALU. It selects one of the lane functions
// by op code and registers the result with a one-cycle done pulse.
// Assumes: start is a single-cycle strobe per request. Back-to-back strobes are legal.
module simd_alu128
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = VEC_W,
    parameter int LANE_S = DWORD_W,
    parameter int LANE_L = QWORD_W,
    parameter int IMM_B  = IMM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_B-1:0]  imm8,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    logic [DATA_W-1:0] sum_s;
    logic [DATA_W-1:0] sum_l;
    logic [DATA_W-1:0] cmp_v;
    logic [DATA_W-1:0] sra_v;
    logic [DATA_W-1:0] shuf_v;
    logic [DATA_W-1:0] next_v;

    simd_lane_add #(.DATA_W(DATA_W), .LANE_W(LANE_S)) u_add_s (
        .x(a), .y(b), .sum(sum_s)
    );

    simd_lane_add #(.DATA_W(DATA_W), .LANE_W(LANE_L)) u_add_l (
        .x(a), .y(b), .sum(sum_l)
    );

    simd_lane_cmp_sra #(.DATA_W(DATA_W), .LANE_W(LANE_S), .CNT_W(IMM_B)) u_cmp_sra (
        .x(a), .y(b), .count(imm8), .gt_mask(cmp_v), .sra_out(sra_v)
    );

    simd_lane_shuffle #(.DATA_W(DATA_W), .LANE_W(LANE_S), .SEL_BITS(IMM_B)) u_shuf (
        .src(b), .sel(imm8), .dst(shuf_v)
    );

    // Purpose: pick the function output named by the op code.
    always_comb begin
        case (alu_op_e'(op))
            OP_ADD32: next_v = sum_s;
            OP_ADD64: next_v = sum_l;
            OP_AND:   next_v = a & b;
            OP_XOR:   next_v = a ^ b;
            OP_CMPGT: next_v = cmp_v;
            OP_SHUF:  next_v = shuf_v;
            OP_SRA:   next_v = sra_v;
            default:  next_v = a;
        endcase
    end

    // Purpose: capture the result on start and pulse done one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                result <= next_v;
            end
        end
    end

endmodule

// File: rtl/simd_alu128_chk.sv
// Module: protocol and function checker for simd_alu128, attached by bind.
// Assumes: the same parameters as the top. It observes ports only.
module simd_alu128_chk #(
    parameter int DATA_W = 128,
    parameter int LANE_S = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] result,
    input logic              done
);
    localparam int NUM_LANES = DATA_W / LANE_S;

    function automatic logic lanes_are_masks(logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (v[i*LANE_S +: LANE_S] != '0 && v[i*LANE_S +: LANE_S] != '1) ok = 1'b0;
        end
        return ok;
    endfunction

    // R1: a reset edge leaves a cleared result and no done.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !done));

    // R2: done follows start by one cycle.
    p_done_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R2: no done without a start.
    p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R2: the result holds between requests.
    p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    // R5: AND result matches the operands of the request.
    p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd2) |=> result == $past(a & b));

    // R5: XOR result matches the operands of the request.
    p_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd3) |=> result == $past(a ^ b));

    // R6: every compare lane is all ones or all zeros.
    p_cmp_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd4) |=> lanes_are_masks(result));

    // R10: the unassigned code passes a through.
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd7) |=> result == $past(a));

endmodule

bind simd_alu128 simd_alu128_chk #(.DATA_W(DATA_W), .LANE_S(LANE_S)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .result(result), .done(done)
);

// File: tb/simd_alu128_tb_top.sv
`timescale 1ns/1ps
module simd_alu128_tb_top;

    typedef struct {
        logic [127:0] val;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = '0;
    logic [127:0] a = '0;
    logic [127:0] b = '0;
    logic [7:0]   imm8 = '0;
    logic [127:0] result;
    logic         done;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t sb_q[$];
    logic last_start = 1'b0;
    logic mon_on = 1'b0;

    always #2.5 clk = ~clk;

    simd_alu128 dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .imm8(imm8), .result(result), .done(done)
    );

    // Reference model, written from the requirements
    function automatic logic [127:0] model(logic [2:0] o, logic [127:0] x,
                                           logic [127:0] y, logic [7:0] im);
        logic [127:0] r;
        r = x;
        case (o)
            3'd0: for (int i = 0; i < 4; i++) r[i*32 +: 32] = x[i*32 +: 32] + y[i*32 +: 32];
            3'd1: for (int i = 0; i < 2; i++) r[i*64 +: 64] = x[i*64 +: 64] + y[i*64 +: 64];
            3'd2: r = x & y;
            3'd3: r = x ^ y;
            3'd4: for (int i = 0; i < 4; i++)
                      r[i*32 +: 32] = ($signed(x[i*32 +: 32]) > $signed(y[i*32 +: 32])) ? 32'hFFFF_FFFF : 32'h0;
            3'd5: for (int i = 0; i < 4; i++) r[i*32 +: 32] = y[int'(im[2*i +: 2])*32 +: 32];
            3'd6: for (int i = 0; i < 4; i++)
                      for (int j = 0; j < 32; j++)
                          r[i*32 + j] = (j + int'(im) < 32) ? x[i*32 + j + int'(im)] : x[i*32 + 31];
            default: r = x;
        endcase
        return r;
    endfunction

    // Driver: present one request and push its expected result.
    task automatic issue(input logic [2:0] o, input logic [127:0] x,
                         input logic [127:0] y, input logic [7:0] im, input string tag);
        exp_t e;
        op = o; a = x; b = y; imm8 = im; start = 1'b1;
        e.val = model(o, x, y, im);
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input logic [127:0] got,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Capture the strobe seen by the design at each edge
    always @(posedge clk) last_start = start;

    // Monitor: check the done level and pop a result at each done
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                check(done == last_start, "R2 done level", 128'(done), 128'(last_start));
                if (done) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R2 unexpected done", result, '0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(result === e.val, e.tag, result, e.val);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired got 0 exp 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        check(result == '0 && !done, "R1 reset state", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R3: lane 0 overflow must not carry into lane 1
        issue(3'd0, 128'h00000001_7FFFFFFF_00000005_FFFFFFFF,
                    128'h00000002_00000001_0000000A_00000001, 8'h00, "R3 add32 carry isolation");
        issue(3'd0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
                    128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 8'hFF, "R3 add32 all ones");
        // R4: 64-bit wrap in lane 0 only
        issue(3'd1, 128'h00000000_00000001_FFFFFFFF_FFFFFFFF,
                    128'h00000000_00000001_00000000_00000001, 8'h00, "R4 add64 wrap");
        issue(3'd1, 128'h12345678_9ABCDEF0_00000000_FFFFFFFF,
                    128'h11111111_11111111_00000000_00000001, 8'h00, "R4 add64 dword carry");
        // R5
        issue(3'd2, 128'hF0F0F0F0_12345678_FFFFFFFF_0000FFFF,
                    128'h0FF00FF0_FFFF0000_A5A5A5A5_FFFF0000, 8'h00, "R5 and");
        issue(3'd3, 128'hF0F0F0F0_12345678_FFFFFFFF_0000FFFF,
                    128'h0FF00FF0_FFFF0000_A5A5A5A5_FFFF0000, 8'h00, "R5 xor");
        // R6: signed compare with mixed signs and equality
        issue(3'd4, 128'h00000001_80000000_00000005_FFFFFFFF,
                    128'hFFFFFFFF_7FFFFFFF_00000005_FFFFFFFE, 8'h00, "R6 cmpgt signed");
        // R7: shuffle patterns
        issue(3'd5, '0, 128'h44444444_33333333_22222222_11111111, 8'h55, "R7 shuffle 0x55");
        issue(3'd5, '0, 128'h44444444_33333333_22222222_11111111, 8'h1B, "R7 shuffle reverse");
        issue(3'd5, '0, 128'h44444444_33333333_22222222_11111111, 8'hE4, "R7 shuffle identity");
        // R8: in-range counts
        issue(3'd6, 128'h80000000_7FFFFFFF_F0000000_12345678, '1, 8'd4, "R8 sra count 4");
        issue(3'd6, 128'h80000000_7FFFFFFF_F0000000_12345678, '0, 8'd0, "R8 sra count 0");
        issue(3'd6, 128'h80000000_7FFFFFFF_F0000000_12345678, '0, 8'd31, "R8 sra count 31");
        // R9: saturated counts
        issue(3'd6, 128'h80000000_7FFFFFFF_F0000000_12345678, '0, 8'd32, "R9 sra count 32");
        issue(3'd6, 128'h80000000_7FFFFFFF_F0000000_12345678, '0, 8'd56, "R9 sra count 56");
        issue(3'd6, 128'h80000000_7FFFFFFF_F0000000_12345678, '0, 8'd255, "R9 sra count 255");
        // R10
        issue(3'd7, 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D, '1, 8'hAA, "R10 pass a");
        idle(2);

        // R2: the result holds while idle
        held = result;
        idle(3);
        check(result == held, "R2 result hold", result, held);

        // Isolated requests with gaps
        issue(3'd0, 128'h1, 128'h2, 8'h00, "R3 isolated add32");
        idle(1);
        issue(3'd4, 128'h7FFFFFFF_00000000_80000000_00000001, 128'h80000000_00000000_7FFFFFFF_00000000,
              8'h00, "R6 isolated cmpgt");
        idle(2);
        check(sb_q.size() == 0, "R2 all results seen", 128'(sb_q.size()), '0);

        // R1: reset after activity
        issue(3'd3, '1, 128'h5, 8'h00, "R5 xor before reset");
        rst_n = 1'b0;
        mon_on = 1'b0;
        @(negedge clk);
        check(result == '0 && !done, "R1 reset clears", result, '0);
        sb_q.delete();
        idle(1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule